// File: doc/BRIEF.md
# Streaming Ternary Dot Product Unit

This block forms the inner product of a stream of signed activations with a stream of ternary weights. Each cycle on which `valid_in` is high, it takes one activation and one 2-bit weight code. Depending on the code, it adds the activation to a hidden running sum, subtracts it, or leaves the sum unchanged. No multiplier is needed.

Once the configured number of elements has been taken, the block shows the completed sum for one cycle and raises `valid_out` with it. It then starts the next vector from zero by itself. The input stream may stall for any number of cycles in the middle of a vector without changing the outcome.

A typical use is one column of a ternary matrix-vector engine. An upstream sequencer pushes one activation per cycle, and the result is picked up when the flag pulses.

Top module: `tdot_stream`

## Requirements
- R1: The vector length is the parameter `VEC_LEN`, default 64. A result is produced after exactly `VEC_LEN` accepted elements, and no result is produced for any other count.
- R2: Weight code 2'b01 adds the activation to the running sum, 2'b10 subtracts it, and 2'b00 and 2'b11 leave the sum unchanged.
- R3: `valid_out` is high for exactly one cycle, in the cycle that follows the clock edge that accepted the last element of a vector.
- R4: `sum_out` reads zero whenever `valid_out` is low.
- R5: While `valid_out` is high, `sum_out` holds the exact two's-complement sum of the vector. The sum is `SUM_W = ACT_W + clog2(VEC_LEN) + 1` bits wide, so it cannot overflow, including for all-extreme activations.
- R6: Cycles with `valid_in` low change neither the element count nor the running sum, whatever values `act_in` and `wcode_in` carry.
- R7: After each result, the running sum and element count restart from zero without any external clear.
- R8: An element accepted in the cycle during which `valid_out` is high is the first element of the next vector.
- R9: Reset clears the element count, the running sum, `sum_out` and `valid_out`. A vector that was cut short by reset produces no result.
- R10: With `VEC_LEN` = 8, all weight codes 2'b01 and activations 1 to 8, the result is 36.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| act_in | input | ACT_W | Signed activation |
| wcode_in | input | 2 | Ternary weight code (00 skip, 01 add, 10 subtract, 11 skip) |
| valid_in | input | 1 | Element present this cycle |
| sum_out | output | SUM_W | Signed vector result; zero outside the result cycle |
| valid_out | output | 1 | One-cycle result flag |

## Verification
The hardest case to reach from the ports is an element that lands exactly in the result cycle. In that cycle the restart of the running sum and the first addition of the next vector must not interfere. The stimulus reaches it by sending two vectors back to back with no idle cycle.

The other hard case is a completion separated from earlier elements by long stalls. Gaps are inserted before the final elements of a vector, with live-looking data on the inputs during the gaps. A reset is also applied in the middle of a vector to show that the partial vector leaves no trace.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

  typedef enum logic [1:0] {
    WC_SKIP = 2'b00,
    WC_ADD  = 2'b01,
    WC_SUB  = 2'b10,
    WC_RSVD = 2'b11
  } wcode_e;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_PLUS,
    OP_MINUS
  } acc_op_e;

  // Map a raw weight code to the accumulator operation; the spare code skips.
  function automatic acc_op_e decode_weight(input logic [1:0] code);
    case (wcode_e'(code))
      WC_ADD:  return OP_PLUS;
      WC_SUB:  return OP_MINUS;
      default: return OP_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/tdot_elem_ctr.sv
module tdot_elem_ctr #(
  parameter int VEC_LEN = 64,
  parameter int CNT_W   = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);

  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(VEC_LEN - 1);

  assign at_last = (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= at_last ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/tdot_acc_cell.sv
module tdot_acc_cell
  import tdot_pkg::*;
#(
  parameter int ACT_W = 8,
  parameter int SUM_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    restart,
  input  logic signed [ACT_W-1:0] act,
  input  logic [1:0]              wcode,
  output logic signed [SUM_W-1:0] acc_q,
  output logic signed [SUM_W-1:0] acc_next
);

  localparam int EXT_W = SUM_W - ACT_W;

  // One ternary step: sign-extend the activation, then add, subtract or hold.
  function automatic logic signed [SUM_W-1:0] tern_step(
    input logic signed [SUM_W-1:0] acc,
    input logic signed [ACT_W-1:0] a,
    input logic [1:0]              code
  );
    logic signed [SUM_W-1:0] a_ext;
    a_ext = {{EXT_W{a[ACT_W-1]}}, a};
    case (decode_weight(code))
      OP_PLUS:  return acc + a_ext;
      OP_MINUS: return acc - a_ext;
      default:  return acc;
    endcase
  endfunction

  assign acc_next = tern_step(acc_q, act, wcode);

  always_ff @(posedge clk) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= restart ? '0 : acc_next;
  end

endmodule

// File: rtl/tdot_result_reg.sv
module tdot_result_reg #(
  parameter int SUM_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic signed [SUM_W-1:0] sum_in,
  output logic signed [SUM_W-1:0] sum_out,
  output logic                    valid_out
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_out   <= '0;
      valid_out <= 1'b0;
    end else begin
      sum_out   <= fire ? sum_in : '0;
      valid_out <= fire;
    end
  end

endmodule

// File: rtl/tdot_stream.sv
module tdot_stream #(
  parameter int VEC_LEN = 64,
  parameter int ACT_W   = 8,
  parameter int SUM_W   = ACT_W + ((VEC_LEN > 1) ? $clog2(VEC_LEN) : 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ACT_W-1:0] act_in,
  input  logic [1:0]              wcode_in,
  input  logic                    valid_in,
  output logic signed [SUM_W-1:0] sum_out,
  output logic                    valid_out
);

  localparam int CNT_W = (VEC_LEN > 1) ? $clog2(VEC_LEN) : 1;

  // Named internal events, used by the bound checker.
  logic                    elem_fire;
  logic                    vec_last;
  logic                    vec_done;
  logic [CNT_W-1:0]        elem_cnt;
  logic signed [SUM_W-1:0] acc_q;
  logic signed [SUM_W-1:0] acc_next;

  assign elem_fire = valid_in;
  assign vec_done  = elem_fire & vec_last;

  tdot_elem_ctr #(.VEC_LEN(VEC_LEN), .CNT_W(CNT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (elem_fire),
    .cnt     (elem_cnt),
    .at_last (vec_last)
  );

  tdot_acc_cell #(.ACT_W(ACT_W), .SUM_W(SUM_W)) u_cell (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (elem_fire),
    .restart  (vec_last),
    .act      (act_in),
    .wcode    (wcode_in),
    .acc_q    (acc_q),
    .acc_next (acc_next)
  );

  tdot_result_reg #(.SUM_W(SUM_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (vec_done),
    .sum_in    (acc_next),
    .sum_out   (sum_out),
    .valid_out (valid_out)
  );

endmodule

// File: rtl/tdot_stream_chk.sv
module tdot_stream_chk #(
  parameter int VEC_LEN = 64,
  parameter int SUM_W   = 16,
  parameter int CNT_W   = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    valid_in,
  input logic                    vec_done,
  input logic [CNT_W-1:0]        elem_cnt,
  input logic signed [SUM_W-1:0] acc_q,
  input logic signed [SUM_W-1:0] sum_out,
  input logic                    valid_out
);

  localparam logic [CNT_W-1:0] MAX_IDX = CNT_W'(VEC_LEN - 1);
  localparam bit MULTI = (VEC_LEN > 1);

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    elem_cnt <= MAX_IDX);

  p_pulse_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |=> valid_out);

  p_no_spurious_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_done |=> !valid_out);

  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (MULTI && valid_out) |=> !valid_out);

  p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_out |-> (sum_out == '0));

  p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(elem_cnt) && $stable(acc_q)));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_done |=> (acc_q == '0 && elem_cnt == '0));

endmodule

bind tdot_stream tdot_stream_chk #(
  .VEC_LEN (VEC_LEN),
  .SUM_W   (SUM_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_in  (valid_in),
  .vec_done  (vec_done),
  .elem_cnt  (elem_cnt),
  .acc_q     (acc_q),
  .sum_out   (sum_out),
  .valid_out (valid_out)
);

// File: tb/tdot_stream_tb.sv
module tdot_stream_tb;

  localparam int VEC_LEN = 8;
  localparam int ACT_W   = 8;
  localparam int SUM_W   = ACT_W + $clog2(VEC_LEN) + 1;

  typedef struct {
    int sum;
    int cyc;
  } exp_t;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic signed [ACT_W-1:0] act_in = '0;
  logic [1:0]              wcode_in = 2'b00;
  logic                    valid_in = 1'b0;
  logic signed [SUM_W-1:0] sum_out;
  logic                    valid_out;

  int   cyc = 0;
  int   ntests = 0;
  int   nfail = 0;
  exp_t expq[$];
  int   run_sum = 0;
  int   run_cnt = 0;
  int   last_sum = 0;
  bit   prev_v = 1'b0;

  tdot_stream #(.VEC_LEN(VEC_LEN), .ACT_W(ACT_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .act_in    (act_in),
    .wcode_in  (wcode_in),
    .valid_in  (valid_in),
    .sum_out   (sum_out),
    .valid_out (valid_out)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: applies one element and pushes the expected result when a vector closes.
  task automatic put(input int a, input int code);
    @(negedge clk);
    act_in   = ACT_W'(a);
    wcode_in = 2'(code);
    valid_in = 1'b1;
    if (code == 1)      run_sum += a;
    else if (code == 2) run_sum -= a;
    run_cnt++;
    if (run_cnt == VEC_LEN) begin
      expq.push_back('{sum: run_sum, cyc: cyc + 1});
      run_sum = 0;
      run_cnt = 0;
    end
  endtask

  // Idle cycles carry live-looking data that must be ignored (R6).
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_in = 1'b0;
      act_in   = ACT_W'(100 + k);
      wcode_in = 2'b01;
    end
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_out) begin
        chk(!prev_v, "R3 single-cycle pulse", 1, 0);
        if (expq.size() == 0) begin
          chk(1'b0, "R1 unexpected result", int'(sum_out), 0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          chk(int'(sum_out) == e.sum, "R5 result value", int'(sum_out), e.sum);
          chk(cyc == e.cyc, "R3 pulse timing", cyc, e.cyc);
        end
        last_sum = int'(sum_out);
      end else begin
        chk(sum_out == '0, "R4 zero while not valid", int'(sum_out), 0);
      end
      prev_v = valid_out;
    end else begin
      prev_v = 1'b0;
    end
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R9: reset state.
    repeat (3) @(negedge clk);
    chk(valid_out == 1'b0, "R9 reset valid_out", int'(valid_out), 0);
    chk(sum_out == '0, "R9 reset sum_out", int'(sum_out), 0);
    rst_n = 1'b1;

    // R10: activations 1..8, all +1 -> 36.
    for (int i = 1; i <= 8; i++) put(i, 1);
    idle(3);
    chk(last_sum == 36, "R10 known vector", last_sum, 36);

    // R2 / R6: all four codes, gaps inserted including before the last element.
    for (int i = 0; i < VEC_LEN; i++) begin
      put(((i * 37 + 5) % 256) - 128, i % 4);
      if (i % 3 == 1 || i == VEC_LEN - 2) idle(4);
    end
    idle(3);

    // R2: subtract-only vector.
    for (int i = 0; i < VEC_LEN; i++) put(i * 11 - 40, 2);
    idle(2);

    // R7 / R8: two vectors back to back; first element of the second lands in the pulse cycle.
    for (int i = 0; i < 2 * VEC_LEN; i++) put((i * 53) % 200 - 100, (i % 2) + 1);
    idle(3);

    // R5: extremes at full width.
    for (int i = 0; i < VEC_LEN; i++) put(-128, 1);
    for (int i = 0; i < VEC_LEN; i++) put(-128, 2);
    idle(3);
    chk(last_sum == 1024, "R5 extreme positive", last_sum, 1024);

    // R9: reset in the middle of a vector drops the partial.
    for (int i = 0; i < 3; i++) put(50, 1);
    @(negedge clk);
    valid_in = 1'b0;
    rst_n = 1'b0;
    run_sum = 0;
    run_cnt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < VEC_LEN; i++) put(i + 1, (i < 4) ? 1 : 0);
    idle(3);
    chk(last_sum == 10, "R9 fresh vector after reset", last_sum, 10);

    // R1: partial vector never produces a result; all expected results seen.
    for (int i = 0; i < VEC_LEN - 1; i++) put(7, 1);
    idle(6);
    chk(expq.size() == 0, "R1 all results produced", expq.size(), 0);

    summary();
    $finish;
  end

endmodule